// File: doc/BRIEF.md
# Age-Counter Replacement Tracker for Four-Way Sets

This block keeps exact use order for every set of a set-associative cache. Each line in a set owns a small age counter, where 0 means most recently used and the largest value means least recently used. The cache controller supplies the set index on every access. When a lookup hits, it pulses a hit strobe together with the hit way. When a lookup misses, it pulses a miss strobe together with the valid bits of the lines in that set.

On a miss the block chooses the way to fill. If the set still has an empty line, it takes the lowest-numbered one. If the set is full, it takes the oldest line. It then updates the counters and, one cycle later, reports the chosen way with a done pulse. Tag compare, data storage and refill timing belong to the surrounding cache.

A hit and a miss strobed in the same cycle are contradictory. Such an input leaves every counter unchanged and raises an error pulse one cycle later.

Top module: `lru_age_tracker`

## Requirements
- R1: After reset, every set holds age value w in way w (way 0 age 0 up to way 3 age 3). A first miss into a full set therefore picks way 3, and no done or error pulse is raised during or just after reset.
- R2: On a hit to way h with old age a, way h's age becomes 0. Every other way whose age is below a gains 1, and ways with age above a keep their value.
- R3: On a miss where at least one valid bit is 0, the chosen way is the lowest-numbered way whose valid bit is 0, and the free-fill flag is 1.
- R4: On a miss where all four valid bits are 1, the chosen way is the way with the highest age (3 in a consistent set; the lowest-numbered such way on a tie), and the free-fill flag is 0.
- R5: On any miss, the chosen way's age becomes 0 and every other way's age gains 1, saturating at 3. No age ever exceeds 3.
- R6: The done pulse, the chosen way and the free-fill flag appear in the cycle after the miss strobe, for exactly one cycle per miss. Back-to-back misses give back-to-back pulses.
- R7: A cycle with both hit and miss strobes raises the error pulse in the next cycle, gives no done pulse, and changes no age.
- R8: Accesses to one set leave the ages of every other set unchanged.
- R9: A hit to the way that already has age 0 leaves all ages of that set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_idx | input | SET_W | Set addressed this cycle |
| hit_vld | input | 1 | Hit strobe |
| hit_way | input | WAY_W | Way that hit |
| miss_vld | input | 1 | Miss strobe |
| line_valid | input | NUM_WAYS | Valid bit of each line of the addressed set (bit w = way w) |
| victim_vld | output | 1 | Miss-done pulse, one cycle after a miss |
| victim_way | output | WAY_W | Way chosen for the fill |
| victim_free | output | 1 | 1 when the fill went to an empty line |
| conflict_err | output | 1 | Pulse one cycle after a simultaneous hit and miss |

## Verification
Every visible result is due on the first rising edge after its strobe. The done pulse, way and free flag after a miss, and the error pulse after a clash, are therefore all sampled a quarter period after that edge. The driver changes inputs on falling edges and queues one expectation for each miss or clash. The monitor pops one expectation at each sample and, with an empty queue, requires both pulses to be low. Hit effects have no output of their own. A reference age model in the bench predicts them, and they are checked through the victims of later full-set misses, including misses right after an ignored clash and misses to untouched sets.

// File: rtl/lru_pkg.sv
package lru_pkg;

   // Kind of counter update applied to the addressed set this cycle
   typedef enum logic [1:0] {
      UPD_NONE = 2'd0,
      UPD_HIT  = 2'd1,
      UPD_FILL = 2'd2
   } upd_kind_e;

   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/lru_free_pick.sv
module lru_free_pick #(
   parameter int WAYS  = 4,
   parameter int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  valid_i,
   output logic             found_o,
   output logic [WAY_W-1:0] way_o
);

   // Scan from the top down so the lowest empty way is the last one written
   always_comb begin
      found_o = 1'b0;
      way_o   = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!valid_i[w]) begin
            found_o = 1'b1;
            way_o   = WAY_W'(w);
         end
      end
   end

endmodule

// File: rtl/lru_oldest_pick.sv
module lru_oldest_pick #(
   parameter int WAYS  = 4,
   parameter int AGE_W = $clog2(WAYS),
   parameter int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][AGE_W-1:0] ages_i,
   output logic [WAY_W-1:0]           way_o
);

   logic [AGE_W-1:0] best_age;

   // Strictly-greater compare keeps the lowest way on a tie
   always_comb begin
      way_o    = '0;
      best_age = ages_i[0];
      for (int w = 1; w < WAYS; w++) begin
         if (ages_i[w] > best_age) begin
            best_age = ages_i[w];
            way_o    = WAY_W'(w);
         end
      end
   end

endmodule

// File: rtl/lru_age_next.sv
module lru_age_next
   import lru_pkg::*;
#(
   parameter int WAYS  = 4,
   parameter int AGE_W = $clog2(WAYS),
   parameter int WAY_W = $clog2(WAYS)
) (
   input  upd_kind_e                  kind_i,
   input  logic [WAY_W-1:0]           touch_i,
   input  logic [WAYS-1:0][AGE_W-1:0] ages_i,
   output logic [WAYS-1:0][AGE_W-1:0] ages_o
);

   localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

   logic [AGE_W-1:0] ref_age;
   assign ref_age = ages_i[touch_i];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      always_comb begin
         ages_o[w] = ages_i[w];
         if (kind_i != UPD_NONE) begin
            if (WAY_W'(w) == touch_i) begin
               ages_o[w] = '0;
            end else if (kind_i == UPD_HIT) begin
               // only lines younger than the touched one move back
               if (ages_i[w] < ref_age) ages_o[w] = ages_i[w] + 1'b1;
            end else begin
               // fill: all others age, clamped at the top value
               if (ages_i[w] != AGE_MAX) ages_o[w] = ages_i[w] + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/lru_age_tracker.sv
module lru_age_tracker
   import lru_pkg::*;
#(
   parameter int NUM_SETS = 4,
   parameter int NUM_WAYS = 4,
   localparam int SET_W   = $clog2(NUM_SETS),
   localparam int WAY_W   = $clog2(NUM_WAYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SET_W-1:0]    set_idx,
   input  logic                hit_vld,
   input  logic [WAY_W-1:0]    hit_way,
   input  logic                miss_vld,
   input  logic [NUM_WAYS-1:0] line_valid,
   output logic                victim_vld,
   output logic [WAY_W-1:0]    victim_way,
   output logic                victim_free,
   output logic                conflict_err
);

   localparam int AGE_W = WAY_W;

   // Elaboration-time parameter checks
   if (!is_pow2(NUM_WAYS)) begin : g_bad_ways
      $error("lru_age_tracker: NUM_WAYS must be a power of two, at least 2");
   end
   if (!is_pow2(NUM_SETS)) begin : g_bad_sets
      $error("lru_age_tracker: NUM_SETS must be a power of two, at least 2");
   end

   typedef logic [NUM_WAYS-1:0][AGE_W-1:0] set_ages_t;

   set_ages_t        ages_q [NUM_SETS];
   set_ages_t        cur_ages;
   set_ages_t        nxt_ages;

   logic             do_hit;
   logic             do_miss;
   logic             clash;
   logic             has_free;
   logic [WAY_W-1:0] free_way;
   logic [WAY_W-1:0] old_way;
   logic [WAY_W-1:0] fill_way;
   logic [WAY_W-1:0] touch_way;
   upd_kind_e        kind;

   assign clash   = hit_vld & miss_vld;
   assign do_hit  = hit_vld & ~miss_vld;
   assign do_miss = miss_vld & ~hit_vld;

   assign cur_ages = ages_q[set_idx];

   lru_free_pick #(
      .WAYS  (NUM_WAYS),
      .WAY_W (WAY_W)
   ) u_free (
      .valid_i (line_valid),
      .found_o (has_free),
      .way_o   (free_way)
   );

   lru_oldest_pick #(
      .WAYS  (NUM_WAYS),
      .AGE_W (AGE_W),
      .WAY_W (WAY_W)
   ) u_oldest (
      .ages_i (cur_ages),
      .way_o  (old_way)
   );

   assign fill_way  = has_free ? free_way : old_way;
   assign touch_way = do_hit ? hit_way : fill_way;

   always_comb begin
      if (do_hit)       kind = UPD_HIT;
      else if (do_miss) kind = UPD_FILL;
      else              kind = UPD_NONE;
   end

   lru_age_next #(
      .WAYS  (NUM_WAYS),
      .AGE_W (AGE_W),
      .WAY_W (WAY_W)
   ) u_next (
      .kind_i  (kind),
      .touch_i (touch_way),
      .ages_i  (cur_ages),
      .ages_o  (nxt_ages)
   );

   // Age storage: one read-modify-write of the addressed set per cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
               ages_q[s][w] <= AGE_W'(w);
            end
         end
      end else if (kind != UPD_NONE) begin
         ages_q[set_idx] <= nxt_ages;
      end
   end

   // Registered miss result and error pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         victim_vld   <= 1'b0;
         victim_way   <= '0;
         victim_free  <= 1'b0;
         conflict_err <= 1'b0;
      end else begin
         victim_vld   <= do_miss;
         victim_free  <= do_miss & has_free;
         conflict_err <= clash;
         if (do_miss) victim_way <= fill_way;
      end
   end

endmodule

// File: rtl/lru_age_tracker_chk.sv
module lru_age_tracker_chk #(
   parameter int NUM_SETS = 4,
   parameter int NUM_WAYS = 4,
   localparam int WAY_W   = $clog2(NUM_WAYS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                hit_vld,
   input logic                miss_vld,
   input logic [NUM_WAYS-1:0] line_valid,
   input logic                victim_vld,
   input logic [WAY_W-1:0]    victim_way,
   input logic                victim_free,
   input logic                conflict_err
);

   logic [NUM_WAYS-1:0] below_mask;
   assign below_mask = (NUM_WAYS'(1) << victim_way) - NUM_WAYS'(1);

   p_done_after_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_vld && !hit_vld) |=> victim_vld);

   p_no_stray_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!miss_vld || hit_vld) |=> !victim_vld);

   p_clash_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vld && miss_vld) |=> (conflict_err && !victim_vld));

   p_no_false_clash_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_vld && miss_vld) |=> !conflict_err);

   p_free_way_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_vld && !hit_vld && !(&line_valid)) |=>
         (victim_free
          && ((($past(line_valid) >> victim_way) & NUM_WAYS'(1)) == '0)
          && (($past(line_valid) & below_mask) == below_mask)));

   p_full_not_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_vld && !hit_vld && (&line_valid)) |=> !victim_free);

   p_free_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      victim_free |-> victim_vld);

endmodule

bind lru_age_tracker lru_age_tracker_chk #(
   .NUM_SETS (NUM_SETS),
   .NUM_WAYS (NUM_WAYS)
) u_chk (.*);

// File: tb/tb_lru_age_tracker.sv
module tb_lru_age_tracker;

   localparam int CLK_PERIOD = 10;
   localparam int NSETS      = 4;
   localparam int NWAYS      = 4;

   typedef struct {
      bit    is_err;
      int    way;
      bit    free;
      string tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] set_idx = '0;
   logic       hit_vld = 1'b0;
   logic [1:0] hit_way = '0;
   logic       miss_vld = 1'b0;
   logic [3:0] line_valid = '0;
   logic       victim_vld;
   logic [1:0] victim_way;
   logic       victim_free;
   logic       conflict_err;

   int   n_checks = 0;
   int   n_fails  = 0;
   bit   mon_on   = 1'b0;
   exp_t exp_q[$];
   int   mage[NSETS][NWAYS];

   always #(CLK_PERIOD / 2) clk = ~clk;

   lru_age_tracker #(.NUM_SETS(NSETS), .NUM_WAYS(NWAYS)) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_idx      (set_idx),
      .hit_vld      (hit_vld),
      .hit_way      (hit_way),
      .miss_vld     (miss_vld),
      .line_valid   (line_valid),
      .victim_vld   (victim_vld),
      .victim_way   (victim_way),
      .victim_free  (victim_free),
      .conflict_err (conflict_err)
   );

   // Reference ages per requirement R1
   task automatic model_reset();
      for (int s = 0; s < NSETS; s++)
         for (int w = 0; w < NWAYS; w++) mage[s][w] = w;
   endtask

   task automatic drive_idle();
      @(negedge clk);
      hit_vld  = 1'b0;
      miss_vld = 1'b0;
   endtask

   // R2 / R9: hit update
   task automatic drive_hit(input int s, input int w);
      int ref_a;
      @(negedge clk);
      set_idx  = 2'(s);
      hit_way  = 2'(w);
      hit_vld  = 1'b1;
      miss_vld = 1'b0;
      ref_a = mage[s][w];
      for (int k = 0; k < NWAYS; k++)
         if (k != w && mage[s][k] < ref_a) mage[s][k]++;
      mage[s][w] = 0;
   endtask

   // R3 / R4 / R5: miss, expected way and update
   task automatic drive_miss(input int s, input logic [3:0] vmask, input string tag);
      exp_t e;
      int   pick;
      bit   fr;
      pick = -1;
      for (int k = 0; k < NWAYS; k++)
         if (pick < 0 && !vmask[k]) pick = k;
      fr = (pick >= 0);
      if (!fr) begin
         pick = 0;
         for (int k = 1; k < NWAYS; k++)
            if (mage[s][k] > mage[s][pick]) pick = k;
      end
      @(negedge clk);
      set_idx    = 2'(s);
      line_valid = vmask;
      miss_vld   = 1'b1;
      hit_vld    = 1'b0;
      for (int k = 0; k < NWAYS; k++)
         if (k != pick && mage[s][k] < NWAYS - 1) mage[s][k]++;
      mage[s][pick] = 0;
      e.is_err = 1'b0; e.way = pick; e.free = fr; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // R7: clash, no model change
   task automatic drive_clash(input int s, input int w, input logic [3:0] vmask);
      exp_t e;
      @(negedge clk);
      set_idx    = 2'(s);
      hit_way    = 2'(w);
      line_valid = vmask;
      hit_vld    = 1'b1;
      miss_vld   = 1'b1;
      e.is_err = 1'b1; e.way = 0; e.free = 1'b0; e.tag = "R7";
      exp_q.push_back(e);
   endtask

   // Monitor: results are due one edge after the strobe (R6)
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_PERIOD / 4);
         if (mon_on) begin
            if (exp_q.size() > 0) begin
               exp_t e;
               e = exp_q.pop_front();
               n_checks++;
               if (e.is_err) begin
                  if (!(conflict_err === 1'b1 && victim_vld === 1'b0)) begin
                     n_fails++;
                     $display("FAIL %s: err=%0d done=%0d, expected err=1 done=0",
                              e.tag, conflict_err, victim_vld);
                  end
               end else begin
                  if (!(victim_vld === 1'b1 && conflict_err === 1'b0 &&
                        int'(victim_way) == e.way && victim_free === e.free)) begin
                     n_fails++;
                     $display("FAIL %s: done=%0d way=%0d free=%0d err=%0d, expected done=1 way=%0d free=%0d err=0",
                              e.tag, victim_vld, victim_way, victim_free, conflict_err,
                              e.way, e.free);
                  end
               end
            end else if (victim_vld !== 1'b0 || conflict_err !== 1'b0) begin
               n_checks++;
               n_fails++;
               $display("FAIL R6/R7 stray pulse: done=%0d err=%0d, expected done=0 err=0",
                        victim_vld, conflict_err);
            end
         end
      end
   end

   // Watchdog
   initial begin
      #(CLK_PERIOD * 100000);
      n_fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      // R1: no pulse while in reset
      n_checks++;
      if (victim_vld !== 1'b0 || conflict_err !== 1'b0 || victim_free !== 1'b0) begin
         n_fails++;
         $display("FAIL R1 reset outputs: done=%0d err=%0d free=%0d, expected 0 0 0",
                  victim_vld, conflict_err, victim_free);
      end
      rst_n = 1'b1;
      mon_on = 1'b1;
      drive_idle();
      drive_idle();

      // R1 + R4: first full miss after reset takes way 3
      drive_miss(0, 4'hF, "R1/R4 first full miss");
      drive_idle();
      // R5 + R6: back-to-back full misses follow the aging order
      drive_miss(0, 4'hF, "R5 second full miss");
      drive_miss(0, 4'hF, "R5 third full miss");
      drive_miss(0, 4'hF, "R6 back-to-back miss");
      drive_idle();
      // R2: hits reorder the set
      drive_hit(0, 0);
      drive_hit(0, 2);
      drive_miss(0, 4'hF, "R2 hit reorder");
      drive_hit(0, 1);
      drive_idle();
      drive_miss(0, 4'hF, "R2 hit on middle age");
      // R9: hit to youngest way changes nothing
      drive_hit(0, 1);
      drive_hit(0, 1);
      drive_miss(0, 4'hF, "R9 youngest hit");
      drive_idle();
      // R7: clash ignored, following miss sees unchanged ages
      drive_clash(0, 3, 4'hF);
      drive_miss(0, 4'hF, "R7 after clash");
      drive_idle();
      // R3: free-line fills in set 1
      drive_miss(1, 4'h0, "R3 empty set");
      drive_miss(1, 4'h1, "R3 one valid");
      drive_miss(1, 4'h5, "R3 gap at way1");
      drive_miss(1, 4'h7, "R3 only way3 free");
      drive_miss(1, 4'hB, "R3 only way2 free");
      drive_miss(1, 4'hF, "R5 full after fills");
      drive_idle();
      // R8: untouched sets keep reset ages
      drive_miss(2, 4'hF, "R8 set2 untouched");
      drive_miss(3, 4'hF, "R8 set3 untouched");
      drive_idle();

      // Mixed traffic against the reference model (R2 R3 R4 R5 R7)
      for (int i = 0; i < 600; i++) begin
         int op;
         int s;
         op = $urandom_range(0, 19);
         s  = $urandom_range(0, NSETS - 1);
         if (op < 7) begin
            drive_hit(s, $urandom_range(0, NWAYS - 1));
         end else if (op < 17) begin
            logic [3:0] vm;
            vm = ($urandom_range(0, 1) == 1) ? 4'hF : 4'($urandom_range(0, 15));
            drive_miss(s, vm, "R4/R5 mixed miss");
         end else if (op < 18) begin
            drive_clash(s, $urandom_range(0, NWAYS - 1), 4'($urandom_range(0, 15)));
         end else begin
            drive_idle();
         end
      end
      drive_idle();
      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_checks++;
         n_fails++;
         $display("FAIL R6 missing results: %0d pending, expected 0", exp_q.size());
      end
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule